// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block runs the digital side of a dual-slope integrating converter. It divides the oscillator clock down to a count rate. It then steps through three phases in a loop: auto-zero, signal integrate and de-integrate. The block drives the analog switch controls for each phase. In de-integrate it also selects the reference direction that brings the integrator back toward zero. The integrator, the reference capacitor and the comparator sit outside the block. The only feedback they return is one comparator bit, which is high while the integrator output is above zero.

The count advances in a chain of BCD decades with a small binary thousands field above them. Signal integrate always runs for one fixed span. De-integrate counts until the comparator changes state, and that count is the reading. Auto-zero then takes whatever time is left, so that every measurement cycle has the same length.

When de-integrate ends, a display latch receives the three BCD digits, the leading half digit, the sign and an overrange flag. The latch holds these values until the next conversion finishes.

Top module: `dual_slope_seq`

## Requirements
- R1: The count advances once every PRESCALE (default 4) oscillator clocks; every phase length is a whole number of such counts.
- R2: Signal integrate lasts exactly 10^NUM_DECADES counts (1000 by default, 4000 clocks).
- R3: At the last integrate count the block stores the comparator level. De-integrate stops on the first count k (starting at 0) on which the comparator differs from that stored level. The reading is then k, and de-integrate has lasted k+1 counts.
- R4: If the comparator has not changed by count 1999, de-integrate stops after 2000 counts. The latch then gets the overrange flag set to 1, half digit 1 and all BCD digits 0.
- R5: Auto-zero ends on the count whose value is 2999. The counter runs on without clearing from de-integrate into auto-zero, so auto-zero takes the unused part of the de-integrate window. Every cycle after the first therefore lasts 4000 counts (16000 clocks).
- R6: During de-integrate, refNeg is 1 when the stored comparator level is high (positive input) and 0 otherwise. refNeg is 0 in every other phase.
- R7: The latch loads only on the clock where de-integrate ends, and holds between loads. The layout is:
  - dispDigits[3:0] holds the units, [7:4] the tens and [11:8] the hundreds, all in BCD.
  - dispHalf holds the thousands digit (0 or 1).
  - dispNeg is 1 when the stored comparator level was low. This sign is latched even for a reading of zero.
  - dispOver is the overrange flag.
- R8: Exactly one of swAutoZero, swIntegrate, swDeint is high at all times.
- R9: Reset puts the block in auto-zero with all counters and the latch cleared. The first auto-zero after reset lasts 3000 counts (12000 clocks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmpHigh | input | 1 | Comparator: integrator output above zero |
| swAutoZero | output | 1 | Auto-zero switch control |
| swIntegrate | output | 1 | Signal-integrate switch control |
| swDeint | output | 1 | De-integrate switch control |
| refNeg | output | 1 | Apply the reference with negative sign during de-integrate |
| dispDigits | output | 12 | Latched BCD digits, hundreds in the top nibble |
| dispHalf | output | 1 | Latched thousands (half) digit |
| dispNeg | output | 1 | Latched sign, 1 = negative |
| dispOver | output | 1 | Latched overrange flag |

## Verification
The bench models the integrator as a signed accumulator that ramps up during integrate and down during de-integrate. It then drives inputs of tiny magnitude and both signs. If the sign were taken from the reading instead of from the stored comparator level, both tiny inputs would read the same sign at zero.

Readings of 1999 and exactly 2000 sit on either side of the overrange edge. An off-by-one in the last-count test would either flag 1999 as overrange or report 2000 as a plain reading.

For every conversion the bench measures the integrate, de-integrate and auto-zero lengths in clocks. A design that cleared the counter on entering auto-zero would break the constant 16000-clock cycle. A late latch load would show a stale reading at the start of auto-zero.

// File: rtl/dss_pkg.sv
package dss_pkg;

  // Width of the binary thousands field above the BCD decades (reaches 2).
  localparam int HI_W = 2;

  typedef enum logic [1:0] {
    PH_AZ  = 2'd0,
    PH_INT = 2'd1,
    PH_DE  = 2'd2
  } phase_t;

  // Strobes from control to datapath, valid for one clock.
  typedef struct packed {
    logic clear;     // zero the whole count
    logic inc;       // advance the count by one
    logic capPol;    // store the comparator level
    logic loadRead;  // load latch with the current count
    logic loadOver;  // load latch with the overrange pattern
  } seqCtrl_t;

  // Datapath status seen by control.
  typedef struct packed {
    logic            lowAllNine;  // every BCD decade holds 9
    logic [HI_W-1:0] hi;          // thousands field
    logic            polHigh;     // stored comparator level
  } seqStat_t;

endpackage

// File: rtl/dss_ctrl.sv
module dss_ctrl
  import dss_pkg::*;
#(
  parameter int PRESCALE = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmpHigh,
  input  seqStat_t stat,
  output seqCtrl_t ctrl,
  output logic     swAutoZero,
  output logic     swIntegrate,
  output logic     swDeint,
  output logic     refNeg
);

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  // Thousands value on the final count of each phase (lower decades all 9).
  localparam logic [HI_W-1:0] HI_INT_END = HI_W'(0);
  localparam logic [HI_W-1:0] HI_DE_LAST = HI_W'(1);
  localparam logic [HI_W-1:0] HI_AZ_END  = HI_W'(2);

  logic [PRE_W-1:0] preCnt;
  logic             tick;
  phase_t           phase, phaseNext;

  assign tick = (preCnt == PRE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      phase  <= PH_AZ;
    end else begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
      phase  <= phaseNext;
    end
  end

  always_comb begin
    ctrl      = '0;
    phaseNext = phase;
    if (tick) begin
      unique case (phase)
        PH_AZ: begin
          if (stat.lowAllNine && stat.hi == HI_AZ_END) begin
            phaseNext  = PH_INT;
            ctrl.clear = 1'b1;
          end else begin
            ctrl.inc = 1'b1;
          end
        end
        PH_INT: begin
          if (stat.lowAllNine && stat.hi == HI_INT_END) begin
            phaseNext   = PH_DE;
            ctrl.clear  = 1'b1;
            ctrl.capPol = 1'b1;
          end else begin
            ctrl.inc = 1'b1;
          end
        end
        PH_DE: begin
          // the count keeps running into auto-zero in every case
          ctrl.inc = 1'b1;
          if (cmpHigh != stat.polHigh) begin
            phaseNext     = PH_AZ;
            ctrl.loadRead = 1'b1;
          end else if (stat.lowAllNine && stat.hi == HI_DE_LAST) begin
            phaseNext     = PH_AZ;
            ctrl.loadOver = 1'b1;
          end
        end
        default: phaseNext = PH_AZ;
      endcase
    end
  end

  assign swAutoZero  = (phase == PH_AZ);
  assign swIntegrate = (phase == PH_INT);
  assign swDeint     = (phase == PH_DE);
  assign refNeg      = swDeint && stat.polHigh;

endmodule

// File: rtl/dss_datapath.sv
module dss_datapath
  import dss_pkg::*;
#(
  parameter int NUM_DECADES = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmpHigh,
  input  seqCtrl_t                 ctrl,
  output seqStat_t                 stat,
  output logic [4*NUM_DECADES-1:0] dispDigits,
  output logic                     dispHalf,
  output logic                     dispNeg,
  output logic                     dispOver
);

  localparam int DIG_W = 4 * NUM_DECADES;

  logic [DIG_W-1:0]       digits;
  logic [NUM_DECADES-1:0] nineVec;
  logic [NUM_DECADES:0]   carry;
  logic [HI_W-1:0]        hi;
  logic                   polHigh;

  assign carry[0] = ctrl.inc;

  for (genvar i = 0; i < NUM_DECADES; i++) begin : g_decade
    logic [3:0] dec;
    assign nineVec[i]       = (dec == 4'd9);
    assign carry[i+1]       = carry[i] && nineVec[i];
    assign digits[4*i +: 4] = dec;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          dec <= '0;
      else if (ctrl.clear) dec <= '0;
      else if (carry[i])  dec <= nineVec[i] ? 4'd0 : dec + 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hi      <= '0;
      polHigh <= 1'b0;
    end else begin
      if (ctrl.clear)                hi <= '0;
      else if (carry[NUM_DECADES])  hi <= hi + 1'b1;
      if (ctrl.capPol)              polHigh <= cmpHigh;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dispDigits <= '0;
      dispHalf   <= 1'b0;
      dispNeg    <= 1'b0;
      dispOver   <= 1'b0;
    end else if (ctrl.loadRead) begin
      dispDigits <= digits;
      dispHalf   <= hi[0];
      dispNeg    <= !polHigh;
      dispOver   <= 1'b0;
    end else if (ctrl.loadOver) begin
      dispDigits <= '0;
      dispHalf   <= 1'b1;
      dispNeg    <= !polHigh;
      dispOver   <= 1'b1;
    end
  end

  assign stat.lowAllNine = &nineVec;
  assign stat.hi         = hi;
  assign stat.polHigh    = polHigh;

endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dss_pkg::*;
#(
  parameter int PRESCALE    = 4,
  parameter int NUM_DECADES = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmpHigh,
  output logic                     swAutoZero,
  output logic                     swIntegrate,
  output logic                     swDeint,
  output logic                     refNeg,
  output logic [4*NUM_DECADES-1:0] dispDigits,
  output logic                     dispHalf,
  output logic                     dispNeg,
  output logic                     dispOver
);

  seqCtrl_t ctrl;
  seqStat_t stat;

  dss_ctrl #(.PRESCALE(PRESCALE)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmpHigh(cmpHigh), .stat(stat), .ctrl(ctrl),
    .swAutoZero(swAutoZero), .swIntegrate(swIntegrate), .swDeint(swDeint),
    .refNeg(refNeg)
  );

  dss_datapath #(.NUM_DECADES(NUM_DECADES)) u_dp (
    .clk(clk), .rstN(rstN), .cmpHigh(cmpHigh), .ctrl(ctrl), .stat(stat),
    .dispDigits(dispDigits), .dispHalf(dispHalf), .dispNeg(dispNeg),
    .dispOver(dispOver)
  );

endmodule

// File: rtl/dss_checker.sv
module dss_checker #(
  parameter int PRESCALE    = 4,
  parameter int NUM_DECADES = 3
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     swAutoZero,
  input logic                     swIntegrate,
  input logic                     swDeint,
  input logic                     refNeg,
  input logic [4*NUM_DECADES-1:0] dispDigits,
  input logic                     dispHalf,
  input logic                     dispNeg,
  input logic                     dispOver
);

  localparam int INT_CLK    = PRESCALE * (10 ** NUM_DECADES);
  localparam int DE_MAX_CLK = 2 * INT_CLK;
  localparam int CYC_CLK    = 4 * INT_CLK;
  localparam int CNT_W      = $clog2(CYC_CLK + 1) + 1;

  logic [CNT_W-1:0] intLen, deLen, cycLen;
  logic             intPrev, seenInt;
  logic             roseInt;

  assign roseInt = swIntegrate && !intPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intLen  <= '0;
      deLen   <= '0;
      cycLen  <= '0;
      intPrev <= 1'b0;
      seenInt <= 1'b0;
    end else begin
      intLen  <= swIntegrate ? intLen + 1'b1 : '0;
      deLen   <= swDeint ? deLen + 1'b1 : '0;
      cycLen  <= roseInt ? CNT_W'(1) : cycLen + 1'b1;
      intPrev <= swIntegrate;
      seenInt <= seenInt || roseInt;
    end
  end

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({swAutoZero, swIntegrate, swDeint})); // R8

  AST_REF_IN_DEINT: assert property (@(posedge clk) disable iff (!rstN)
    refNeg |-> swDeint); // R6

  AST_LATCH_AT_DE_END: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({dispDigits, dispHalf, dispNeg, dispOver}) |-> $fell(swDeint)); // R7

  AST_INT_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(swIntegrate) |-> intLen == CNT_W'(INT_CLK)); // R2

  AST_DEINT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    swDeint |-> deLen < CNT_W'(DE_MAX_CLK)); // R4

  AST_CYCLE_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    (roseInt && seenInt) |-> cycLen == CNT_W'(CYC_CLK)); // R5

endmodule

bind dual_slope_seq dss_checker #(.PRESCALE(PRESCALE), .NUM_DECADES(NUM_DECADES)) u_dssChk (
  .clk(clk), .rstN(rstN), .swAutoZero(swAutoZero), .swIntegrate(swIntegrate),
  .swDeint(swDeint), .refNeg(refNeg), .dispDigits(dispDigits),
  .dispHalf(dispHalf), .dispNeg(dispNeg), .dispOver(dispOver)
);

// File: tb/tb_dual_slope_seq.sv
`timescale 1ns/1ps
module tb_dual_slope_seq;

  localparam int NV = 7;
  // input per clock in milli-counts; expected reading, sign, overrange
  localparam longint VEC_VIN  [0:NV-1] = '{1, -1, 500000, -1234000, 1999000, 2000000, -37000};
  localparam int     VEC_RD   [0:NV-1] = '{0, 0, 500, 1234, 1999, 0, 37};
  localparam bit     VEC_NEG  [0:NV-1] = '{0, 1, 0, 1, 0, 0, 1};
  localparam bit     VEC_OVER [0:NV-1] = '{0, 0, 0, 0, 0, 1, 0};
  localparam longint REF_STEP = 1000000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmpHigh;
  logic        swAutoZero, swIntegrate, swDeint, refNeg;
  logic [11:0] dispDigits;
  logic        dispHalf, dispNeg, dispOver;

  longint vin = 0;
  longint acc;
  longint cyc = 0;
  int     checks = 0;
  int     failures = 0;
  bit     done = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // integrator and comparator model
  always_ff @(posedge clk) begin
    if (!rstN || swAutoZero) acc <= 0;
    else if (swIntegrate)    acc <= acc + vin;
    else if (swDeint)        acc <= refNeg ? acc - REF_STEP : acc + REF_STEP;
  end
  assign cmpHigh = (acc > 0);

  dual_slope_seq dut (
    .clk(clk), .rstN(rstN), .cmpHigh(cmpHigh), .swAutoZero(swAutoZero),
    .swIntegrate(swIntegrate), .swDeint(swDeint), .refNeg(refNeg),
    .dispDigits(dispDigits), .dispHalf(dispHalf), .dispNeg(dispNeg),
    .dispOver(dispOver)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitSig(input int which);
    do @(negedge clk);
    while (!((which == 0 && swAutoZero) || (which == 1 && swIntegrate) || (which == 2 && swDeint)));
  endtask

  function automatic logic [11:0] toBcd(input int d);
    return {4'((d / 100) % 10), 4'((d / 10) % 10), 4'(d % 10)};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    longint t0, tInt, tDe, tAz, tNext;
    logic [11:0] expDig;
    bit expHalf;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(swAutoZero && !swIntegrate && !swDeint && !refNeg, "R9 reset phase",
          {swAutoZero, swIntegrate, swDeint}, 3'b100);
    check({dispDigits, dispHalf, dispNeg, dispOver} == '0, "R9 reset latch",
          {dispDigits, dispHalf, dispNeg, dispOver}, 0);
    vin = VEC_VIN[0];
    rstN = 1'b1;
    t0 = cyc;
    waitSig(1);
    tInt = cyc;
    check(tInt - t0 == 12000, "R9 first auto-zero clocks", tInt - t0, 12000);

    for (int i = 0; i < NV; i++) begin
      waitSig(2);
      tDe = cyc;
      check(tDe - tInt == 4000, "R2 R1 integrate clocks", tDe - tInt, 4000);
      check(refNeg == !VEC_NEG[i], "R6 reference direction", refNeg, !VEC_NEG[i]);
      waitSig(0);
      tAz = cyc;
      check(!refNeg, "R6 refNeg low outside de-integrate", refNeg, 0);
      if (VEC_OVER[i]) begin
        check(tAz - tDe == 8000, "R4 overrange de-integrate clocks", tAz - tDe, 8000);
        expDig = '0;
        expHalf = 1'b1;
      end else begin
        check(tAz - tDe == 4 * (VEC_RD[i] + 1), "R3 de-integrate clocks",
              tAz - tDe, 4 * (VEC_RD[i] + 1));
        expDig = toBcd(VEC_RD[i]);
        expHalf = (VEC_RD[i] >= 1000);
      end
      check(dispDigits == expDig, "R3 R7 BCD digits", dispDigits, expDig);
      check(dispHalf == expHalf, "R7 half digit", dispHalf, expHalf);
      check(dispNeg == VEC_NEG[i], "R6 R7 latched sign", dispNeg, VEC_NEG[i]);
      check(dispOver == VEC_OVER[i], "R4 overrange flag", dispOver, VEC_OVER[i]);
      vin = (i + 1 < NV) ? VEC_VIN[i+1] : 64'sd500000;
      waitSig(1);
      tNext = cyc;
      check(tNext - tInt == 16000, "R5 cycle clocks", tNext - tInt, 16000);
      check(dispDigits == expDig && dispOver == VEC_OVER[i], "R7 latch holds in auto-zero",
            dispDigits, expDig);
      tInt = tNext;
    end

    // R9: reset in the middle of de-integrate
    waitSig(2);
    repeat (20) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(swAutoZero && !swDeint && !refNeg, "R9 mid-run reset phase",
          {swAutoZero, swIntegrate, swDeint}, 3'b100);
    check({dispDigits, dispHalf, dispNeg, dispOver} == '0, "R9 mid-run reset latch",
          {dispDigits, dispHalf, dispNeg, dispOver}, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule